// File: doc/BRIEF.md
# SPI Slave with Receive and Transmit Queues

This block is a serial peripheral interface slave clocked by a fast system clock. It oversamples the external serial clock, the active-low slave select and the serial input through two-flop synchronizers. From the edges it sees, it counts bits, assembles received words and drives transmit words out on the serial output. Clock polarity, clock phase, bit order and word length (8 or 16 bits) are set by static configuration inputs. These inputs may only change while slave select is high.

A host reads received words and writes transmit words through a simple strobe-based port. In single-buffer mode each direction holds one word, and a new received word overwrites the held one. In queue mode both directions hold up to eight words in order. A receive word that finds the queue full is dropped and raises a sticky overflow flag. When no transmit word is waiting at the start of a word, the slave sends zeros. Raising slave select in the middle of a word aborts it and throws the partial word away.

Top module: `spi_slave_fifo`

## Requirements
- R1: After reset, rx_full_o, rx_ovf_o, tx_full_o and miso_o are all 0.
- R2: With cpha_i=0, the first bit of a transmit word is on miso_o once slave select is low, before any clock edge. The serial input is sampled on leading edges, and the output advances on trailing edges.
- R3: With cpha_i=1, the first transmit bit is driven at the first leading edge of each word. The serial input is sampled on trailing edges.
- R4: With cpol_i=1 the serial clock idles high, and the leading edge is the falling edge. With cpol_i=0 the leading edge is the rising edge.
- R5: With lsb_first_i=1, bit 0 of a word goes first in both directions. With lsb_first_i=0, the top bit of the word goes first.
- R6: A word is complete after 8 sampled bits when half_i=0, or 16 when half_i=1. An 8-bit word is read back in rd_data_o[7:0] with the upper byte 0.
- R7: A completed word sets rx_full_o. In single-buffer mode (fifo_en_i=0), a read pulse on rd_en_i clears it, and a newer word replaces an unread one.
- R8: With fifo_en_i=1, up to 8 words queue in each direction in arrival order. tx_full_o is 1 when the transmit side holds 8 words (1 word in single-buffer mode), and a write while full is ignored.
- R9: With fifo_en_i=1, a word completed while 8 received words are held is dropped and sets rx_ovf_o. A read pulse clears rx_ovf_o.
- R10: A word that starts while the transmit side is empty is sent as all zeros.
- R11: Raising slave select mid-word resets the bit count and discards the partial word. The next word starts cleanly.
- R12: miso_o is 0 while slave select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpol_i | input | 1 | Serial clock idle level |
| cpha_i | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| lsb_first_i | input | 1 | Bit order select |
| half_i | input | 1 | 0: 8-bit words, 1: 16-bit words |
| fifo_en_i | input | 1 | 1: 8-deep queues, 0: single buffers |
| sck_i | input | 1 | Serial clock from master |
| ss_ni | input | 1 | Slave select, active low |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out |
| wr_en_i | input | 1 | Transmit word write strobe |
| wr_data_i | input | 16 | Transmit word |
| rd_en_i | input | 1 | Receive word read strobe (pops head) |
| rd_data_o | output | 16 | Head of receive side |
| rx_full_o | output | 1 | Receive side holds at least one word |
| rx_ovf_o | output | 1 | Sticky receive overflow |
| tx_full_o | output | 1 | Transmit side at capacity |

## Verification
A wrong bit counter or edge choice shows within one word. The received word comes back shifted or with bits out of place, and the word the master collects from miso_o no longer matches what the host wrote. A queue pointer or count fault shows only across several words: as reordered or repeated reads, as an overflow that comes one word early or late, or as nonzero data sent when the transmit side should be empty. For that reason the bench runs multi-word frames and fills each queue past its limit.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;
  typedef struct packed {
    logic cpol;
    logic cpha;
    logic lsb_first;
    logic half;
  } spi_fmt_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned N = 1,
  parameter logic [N-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] s0, s1;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s0 <= RST;
      s1 <= RST;
    end else begin
      s0 <= d_i;
      s1 <= s0;
    end
  end
  assign q_o = s1;
endmodule

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            pop_i,
  output logic [DW-1:0]   rdata_o,
  output logic [CNTW-1:0] count_o
);
  logic [DW-1:0]   mem [DEPTH];
  logic [AW-1:0]   wr_ptr, rd_ptr;
  logic [CNTW-1:0] cnt;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_i) wr_ptr <= nxt(wr_ptr);
      if (pop_i)  rd_ptr <= nxt(rd_ptr);
      if (push_i && !pop_i)      cnt <= cnt + 1'b1;
      else if (pop_i && !push_i) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_ptr] <= wdata_i;
  end

  assign rdata_o = mem[rd_ptr];
  assign count_o = cnt;
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_slave_pkg::*;
#(
  parameter int unsigned DW = 16,
  localparam int unsigned HW = DW / 2,
  localparam int unsigned CW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  spi_fmt_t      fmt_i,
  input  logic          active_i,
  input  logic          sck_i,
  input  logic          mosi_i,
  input  logic          tx_avail_i,
  input  logic [DW-1:0] tx_word_i,
  output logic          tx_pop_o,
  output logic          miso_o,
  output logic          done_o,
  output logic [DW-1:0] rx_word_o,
  output logic [CW-1:0] bit_cnt_o
);
  logic          sck_eff, sck_q, lead, trail, sample_edge, drive_edge;
  logic          loaded, load, shift_out, last;
  logic [CW-1:0] bit_cnt, wlast;
  logic [DW-1:0] txs, rxs, rx_next, mask;

  assign sck_eff     = sck_i ^ fmt_i.cpol;
  assign lead        = active_i && sck_eff && !sck_q;
  assign trail       = active_i && !sck_eff && sck_q;
  assign sample_edge = fmt_i.cpha ? trail : lead;
  assign drive_edge  = fmt_i.cpha ? lead : trail;
  assign wlast       = fmt_i.half ? CW'(DW - 1) : CW'(HW - 1);
  assign last        = (bit_cnt == wlast);
  assign mask        = fmt_i.half ? '1 : DW'({HW{1'b1}});

  // phase 0 loads at word start; phase 1 loads on first leading edge
  assign load      = active_i && (fmt_i.cpha ? (drive_edge && bit_cnt == '0) : !loaded);
  assign shift_out = drive_edge && (bit_cnt != '0);
  assign tx_pop_o  = load && tx_avail_i;

  always_comb begin
    if (fmt_i.lsb_first) begin
      rx_next = rxs >> 1;
      if (fmt_i.half) rx_next[DW-1] = mosi_i;
      else            rx_next[HW-1] = mosi_i;
    end else begin
      rx_next = {rxs[DW-2:0], mosi_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q   <= 1'b0;
      bit_cnt <= '0;
      loaded  <= 1'b0;
      txs     <= '0;
      rxs     <= '0;
    end else begin
      sck_q <= sck_eff;
      if (!active_i) begin
        bit_cnt <= '0;
        loaded  <= 1'b0;
        txs     <= '0;
      end else begin
        if (load) begin
          txs    <= tx_avail_i ? tx_word_i : '0;
          loaded <= 1'b1;
        end else if (shift_out) begin
          txs <= fmt_i.lsb_first ? (txs >> 1) : (txs << 1);
        end
        if (sample_edge) begin
          rxs <= rx_next;
          if (last) begin
            bit_cnt <= '0;
            loaded  <= 1'b0;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
      end
    end
  end

  assign miso_o    = active_i && (fmt_i.lsb_first ? txs[0]
                                  : (fmt_i.half ? txs[DW-1] : txs[HW-1]));
  assign done_o    = sample_edge && last;
  assign rx_word_o = rx_next & mask;
  assign bit_cnt_o = bit_cnt;
endmodule

// File: rtl/spi_slave_fifo.sv
module spi_slave_fifo
  import spi_slave_pkg::*;
#(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNTW = $clog2(DEPTH + 1),
  localparam int unsigned CW   = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cpol_i,
  input  logic          cpha_i,
  input  logic          lsb_first_i,
  input  logic          half_i,
  input  logic          fifo_en_i,
  input  logic          sck_i,
  input  logic          ss_ni,
  input  logic          mosi_i,
  output logic          miso_o,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rx_full_o,
  output logic          rx_ovf_o,
  output logic          tx_full_o
);
  logic            ss_s, sck_s, mosi_s, ss_act;
  logic [CNTW-1:0] cap, rx_cnt, tx_cnt;
  logic            word_done, tx_pop, rx_push, rx_pop, tx_push, rx_room;
  logic [DW-1:0]   rx_word, tx_head;
  logic [CW-1:0]   bit_cnt;
  spi_fmt_t        fmt;

  spi_sync #(.N(3), .RST(3'b100)) u_sync (
    .clk_i, .rst_ni,
    .d_i({ss_ni, sck_i, mosi_i}),
    .q_o({ss_s, sck_s, mosi_s})
  );

  assign ss_act = !ss_s;
  assign fmt    = '{cpol: cpol_i, cpha: cpha_i, lsb_first: lsb_first_i, half: half_i};
  assign cap    = fifo_en_i ? CNTW'(DEPTH) : CNTW'(1);

  spi_shift_engine #(.DW(DW)) u_eng (
    .clk_i, .rst_ni,
    .fmt_i(fmt),
    .active_i(ss_act),
    .sck_i(sck_s),
    .mosi_i(mosi_s),
    .tx_avail_i(tx_cnt != '0),
    .tx_word_i(tx_head),
    .tx_pop_o(tx_pop),
    .miso_o(miso_o),
    .done_o(word_done),
    .rx_word_o(rx_word),
    .bit_cnt_o(bit_cnt)
  );

  // single-buffer mode: new word displaces the held one
  assign rx_room = rx_cnt < cap;
  assign rx_push = word_done && (rx_room || !fifo_en_i);
  assign rx_pop  = (rx_cnt != '0) && (rd_en_i || (word_done && !fifo_en_i));
  assign tx_push = wr_en_i && (tx_cnt < cap);

  spi_word_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk_i, .rst_ni,
    .push_i(rx_push), .wdata_i(rx_word),
    .pop_i(rx_pop), .rdata_o(rd_data_o), .count_o(rx_cnt)
  );

  spi_word_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk_i, .rst_ni,
    .push_i(tx_push), .wdata_i(wr_data_i),
    .pop_i(tx_pop), .rdata_o(tx_head), .count_o(tx_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 rx_ovf_o <= 1'b0;
    else if (word_done && fifo_en_i && !rx_room) rx_ovf_o <= 1'b1;
    else if (rd_en_i)                            rx_ovf_o <= 1'b0;
  end

  assign rx_full_o = rx_cnt != '0;
  assign tx_full_o = tx_cnt >= cap;
endmodule

// File: rtl/spi_slave_fifo_chk.sv
module spi_slave_fifo_chk #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNTW = $clog2(DEPTH + 1),
  localparam int unsigned CW   = $clog2(DW)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            ss_act,
  input logic            miso_o,
  input logic            half_i,
  input logic            fifo_en_i,
  input logic            word_done,
  input logic            rx_full_o,
  input logic            rx_ovf_o,
  input logic [CNTW-1:0] rx_cnt,
  input logic [CW-1:0]   bit_cnt
);
  a_r12_miso_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ss_act |-> !miso_o);

  a_r7_done_sets_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_done |=> rx_full_o);

  a_r9_ovf_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_ovf_o) |-> $past(fifo_en_i && rx_cnt == CNTW'(DEPTH)));

  a_r11_abort_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ss_act |=> bit_cnt == '0);

  a_r8_rx_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_cnt <= CNTW'(DEPTH));

  a_r6_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_i || (bit_cnt < CW'(DW / 2)));
endmodule

bind spi_slave_fifo spi_slave_fifo_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ss_act(ss_act), .miso_o(miso_o),
  .half_i(half_i), .fifo_en_i(fifo_en_i), .word_done(word_done),
  .rx_full_o(rx_full_o), .rx_ovf_o(rx_ovf_o), .rx_cnt(rx_cnt), .bit_cnt(bit_cnt)
);

// File: tb/spi_slave_fifo_bench.sv
module spi_slave_fifo_bench;
  localparam int H = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cpol = 0, cpha = 0, lsb = 0, half = 0, fen = 0;
  logic sck = 0, ss_n = 1, mosi = 0, miso;
  logic wr_en = 0, rd_en = 0;
  logic [15:0] wr_data = '0, rd_data;
  logic rx_full, rx_ovf, tx_full;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_slave_fifo u_spi_slave_fifo (
    .clk_i(clk), .rst_ni(rst_ni), .cpol_i(cpol), .cpha_i(cpha),
    .lsb_first_i(lsb), .half_i(half), .fifo_en_i(fen),
    .sck_i(sck), .ss_ni(ss_n), .mosi_i(mosi), .miso_o(miso),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_data),
    .rx_full_o(rx_full), .rx_ovf_o(rx_ovf), .tx_full_o(tx_full)
  );

  task automatic wc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string r, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  function automatic logic [15:0] wmask(input logic [15:0] v, input logic h);
    return h ? v : {8'h00, v[7:0]};
  endfunction

  task automatic set_cfg(input logic pl, input logic ph, input logic lf,
                         input logic hf, input logic fe);
    cpol = pl; cpha = ph; lsb = lf; half = hf; fen = fe; sck = pl;
    wc(8);
  endtask

  task automatic host_wr(input logic [15:0] d);
    wr_data = d; wr_en = 1; wc(1); wr_en = 0;
  endtask

  task automatic host_rd(output logic [15:0] d);
    d = rd_data; rd_en = 1; wc(1); rd_en = 0;
  endtask

  task automatic ss_low();
    ss_n = 0; wc(H);
  endtask

  task automatic ss_high();
    wc(H); ss_n = 1; wc(H);
  endtask

  // master model; nbits < word length gives a partial word
  task automatic xfer(input logic [15:0] mo, input int nbits, output logic [15:0] mi);
    int w = half ? 16 : 8;
    mi = '0;
    for (int i = 0; i < nbits; i++) begin
      int b = lsb ? i : w - 1 - i;
      if (!cpha) begin
        mosi = mo[b]; wc(H); mi[b] = miso;
        sck = ~cpol; wc(H); sck = cpol;
      end else begin
        sck = ~cpol; mosi = mo[b]; wc(H); mi[b] = miso;
        sck = cpol; wc(H);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] mi, rd, tw, mw;
    logic [15:0] exp_q [9];
    int seed;
    seed = $urandom(32'h5eed_0042);

    wc(4);
    chk("R1 rx_full", 16'(rx_full), 16'h0);
    chk("R1 rx_ovf", 16'(rx_ovf), 16'h0);
    chk("R1 tx_full", 16'(tx_full), 16'h0);
    chk("R1 miso", 16'(miso), 16'h0);
    rst_ni = 1; wc(4);

    // R2: first bit out before any clock edge
    set_cfg(0, 0, 0, 0, 0);
    host_wr(16'h00A5);
    ss_low();
    chk("R2 first bit pre-edge", 16'(miso), 16'h1);
    xfer(16'h003C, 8, mi);
    ss_high();
    chk("R2 miso word", mi, 16'h00A5);
    chk("R12 miso idle", 16'(miso), 16'h0);
    chk("R7 rx_full set", 16'(rx_full), 16'h1);
    host_rd(rd);
    chk("R6 rx byte", rd, 16'h003C);
    chk("R7 rx_full cleared", 16'(rx_full), 16'h0);

    // R3: phase 1
    set_cfg(0, 1, 0, 0, 0);
    host_wr(16'h005A);
    ss_low();
    chk("R3 no bit before first edge", 16'(miso), 16'h0);
    xfer(16'h00C3, 8, mi);
    ss_high();
    chk("R3 miso word", mi, 16'h005A);
    host_rd(rd);
    chk("R3 rx word", rd, 16'h00C3);

    // R4 / R5: idle-high clock, LSB first, 16-bit
    set_cfg(1, 0, 1, 1, 0);
    host_wr(16'h1234);
    ss_low();
    chk("R5 lsb first bit", 16'(miso), 16'h0);
    xfer(16'hBEEF, 16, mi);
    ss_high();
    chk("R5 miso lsb-first", mi, 16'h1234);
    host_rd(rd);
    chk("R4 rx idle-high", rd, 16'hBEEF);

    // random formats, single-buffer
    for (int k = 0; k < 24; k++) begin
      logic [3:0] f;
      f = 4'($urandom);
      set_cfg(f[0], f[1], f[2], f[3], 0);
      tw = wmask(16'($urandom), f[3]);
      mw = 16'($urandom);
      host_wr(tw);
      ss_low();
      xfer(mw, f[3] ? 16 : 8, mi);
      ss_high();
      chk(f[1] ? "R3 random miso" : "R2 random miso", mi, tw);
      chk("R7 random rx_full", 16'(rx_full), 16'h1);
      host_rd(rd);
      chk("R6 random rx", rd, wmask(mw, f[3]));
    end

    // R7: overwrite in single-buffer mode
    set_cfg(0, 1, 0, 0, 0);
    ss_low();
    xfer(16'h0011, 8, mi);
    xfer(16'h0022, 8, mi);
    ss_high();
    host_rd(rd);
    chk("R7 newest word kept", rd, 16'h0022);
    chk("R7 empty after read", 16'(rx_full), 16'h0);

    // R11: abort mid-word
    set_cfg(0, 0, 0, 0, 0);
    ss_low();
    xfer(16'h00FF, 3, mi);
    ss_high();
    chk("R11 no word after abort", 16'(rx_full), 16'h0);
    ss_low();
    xfer(16'h0096, 8, mi);
    ss_high();
    host_rd(rd);
    chk("R11 clean word after abort", rd, 16'h0096);

    // R9 / R10: rx queue fill past depth, tx empty
    set_cfg(0, 1, 1, 1, 1);
    ss_low();
    for (int k = 0; k < 9; k++) begin
      exp_q[k] = 16'($urandom);
      xfer(exp_q[k], 16, mi);
      chk("R10 zeros when tx empty", mi, 16'h0000);
    end
    ss_high();
    chk("R9 overflow set", 16'(rx_ovf), 16'h1);
    for (int k = 0; k < 8; k++) begin
      host_rd(rd);
      chk("R8 rx order", rd, exp_q[k]);
      if (k == 0) chk("R9 overflow cleared", 16'(rx_ovf), 16'h0);
    end
    chk("R9 ninth dropped", 16'(rx_full), 16'h0);

    // R8: tx queue
    set_cfg(0, 0, 0, 0, 1);
    for (int k = 0; k < 8; k++) begin
      exp_q[k] = {8'h00, 8'($urandom)};
      host_wr(exp_q[k]);
    end
    wc(1);
    chk("R8 tx_full at 8", 16'(tx_full), 16'h1);
    host_wr(16'h00EE);
    ss_low();
    for (int k = 0; k < 8; k++) begin
      xfer(16'h0000, 8, mi);
      chk("R8 tx order", mi, exp_q[k]);
    end
    xfer(16'h0000, 8, mi);
    chk("R8 write when full ignored", mi, 16'h0000);
    ss_high();
    chk("R8 tx_full clear", 16'(tx_full), 16'h0);
    chk("R12 miso idle end", 16'(miso), 16'h0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule